// File: doc/BRIEF.md
# Keypad PIN Lock Controller

This block sits behind a keypad scanner and receives one decoded key event per cycle: ten digits, a confirm key and four function keys. It gathers the digits of a PIN attempt and compares them with a stored PIN when confirm is pressed. A match raises the unlock output, which then stays high until reset. A mismatch counts as a failed attempt. When the count of failures reaches a limit, the block issues a one-cycle wipe request.

While the lock is closed, the first function key starts a PIN change. The change asks for the current PIN, then the new PIN twice. Every accepted key starts a short beeper pulse train. A failed confirm plays an error tone in its place; this tone toggles at a slower rate. A small key-state register holds the last key for a host that polls it. The register clears after the host has read it once.

Top module: `pin_lock_ctrl`

## Requirements
- R1: Key codes on `key_code_i` are 0 to 9 for digits, 10 for confirm, 11 to 14 for the function keys F1 to F4. Code 15 is ignored: it gives no beep and leaves the key-state register unchanged.
- R2: On each accepted key, `key_state_o` loads the key code plus one (values 1 to 15). A `host_rd_i` pulse clears it to 0 in the next cycle. If a key arrives in the same cycle as a read, the new key's value is loaded. The register reads 0 after reset.
- R3: A confirm succeeds only if 6 to 9 digits have been entered. Any other count is a failed attempt.
- R4: In the locked state, a confirm with the stored PIN raises `unlock_o` in the next cycle and clears `attempts_o`. `unlock_o` then stays high until reset. The reset PIN is 1,2,3,4,5,6.
- R5: Each failed PIN check increments `attempts_o` by one.
- R6: The failure that brings the count to ATTEMPT_LIMIT (15) pulses `wipe_o` for exactly one cycle and returns `attempts_o` to 0.
- R7: F1 pressed while locked starts a PIN change and discards the digits entered so far. F1 pressed while unlocked has no effect. Digits and confirm pressed while unlocked also have no effect.
- R8: A PIN change asks for the old PIN, then the new PIN twice. A wrong old PIN counts as a failed attempt. The new PIN replaces the stored one only if both entries match and have 6 to 9 digits. Any failure returns the block to locked and keeps the old PIN.
- R9: F2, F3 and F4 beep and update the key-state register, but they leave the entered digits and the lock state unchanged.
- R10: Every accepted key restarts a beep train of TONE_LEN cycles. `beep_o` is high for the first KEY_HALF cycles and then toggles every KEY_HALF cycles.
- R11: A failed confirm starts the error tone in place of the key beep. The error tone has the same length and toggles every ERR_HALF cycles.
- R12: Digits beyond the ninth saturate the entry. The confirm that follows fails.
- R13: After reset the block is locked, with `attempts_o`, `wipe_o` and `beep_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | Key event strobe |
| key_code_i | input | 4 | Key code (see R1) |
| host_rd_i | input | 1 | Host read of the key-state register |
| key_state_o | output | 4 | Last key plus one, or 0 when idle |
| unlock_o | output | 1 | Lock open |
| beep_o | output | 1 | Beeper drive |
| wipe_o | output | 1 | One-cycle data wipe request |
| attempts_o | output | AW (4 by default) | Failed attempt count |

## Verification
A host read and a new key event can fall in the same cycle. The read clears the key-state register, while the key loads it. The bench drives a key together with a read pulse in directed and random presses. It expects the new key's code plus one, not zero, in the next cycle. A read with no key present must give 0.

// File: rtl/pin_lock_pkg.sv
package pin_lock_pkg;
  typedef enum logic [2:0] {
    ST_LOCKED,
    ST_OPEN,
    ST_CHG_OLD,
    ST_CHG_NEW1,
    ST_CHG_NEW2
  } lock_state_e;

  localparam logic [3:0] KEY_OK   = 4'd10;
  localparam logic [3:0] KEY_F1   = 4'd11;
  localparam logic [3:0] KEY_NONE = 4'd15;
endpackage

// File: rtl/pin_entry_buf.sv
module pin_entry_buf #(
  parameter int MAX_DIGITS = 9,
  parameter int CW = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    digit_en_i,
  input  logic [3:0]              digit_i,
  output logic [4*MAX_DIGITS-1:0] digits_o,
  output logic [CW-1:0]           count_o
);
  logic [CW-1:0] cnt_q;
  logic [3:0]    slot_q [MAX_DIGITS];

  // count saturates one past the last slot to mark overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (digit_en_i && cnt_q <= CW'(MAX_DIGITS - 1)) cnt_q <= cnt_q + 1'b1;
    else if (digit_en_i && cnt_q == CW'(MAX_DIGITS)) cnt_q <= CW'(MAX_DIGITS + 1);
  end

  for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (digit_en_i && !clear_i && cnt_q == CW'(g)) slot_q[g] <= digit_i;
    end
    assign digits_o[4*g +: 4] = slot_q[g];
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pin_cmp.sv
module pin_cmp #(
  parameter int MAX_DIGITS = 9,
  parameter int CW = 4
) (
  input  logic [4*MAX_DIGITS-1:0] a_digits_i,
  input  logic [CW-1:0]           a_len_i,
  input  logic [4*MAX_DIGITS-1:0] b_digits_i,
  input  logic [CW-1:0]           b_len_i,
  output logic                    eq_o
);
  logic diff;

  always_comb begin
    diff = 1'b0;
    for (int i = 0; i < MAX_DIGITS; i++) begin
      if (CW'(i) < a_len_i && a_digits_i[4*i +: 4] != b_digits_i[4*i +: 4]) diff = 1'b1;
    end
    eq_o = (a_len_i == b_len_i) && !diff;
  end
endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int TONE_LEN = 7_000_000,
  parameter int KEY_HALF = 25_000,
  parameter int ERR_HALF = 60_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic err_i,
  output logic beep_o
);
  localparam int MAXH = (ERR_HALF > KEY_HALF) ? ERR_HALF : KEY_HALF;
  localparam int LW   = $clog2(TONE_LEN) + 1;
  localparam int HW   = $clog2(MAXH) + 1;

  logic          active_q, phase_q, err_q;
  logic [LW-1:0] len_q;
  logic [HW-1:0] half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      err_q    <= 1'b0;
      len_q    <= '0;
      half_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      phase_q  <= 1'b1;
      err_q    <= err_i;
      len_q    <= LW'(TONE_LEN - 1);
      half_q   <= err_i ? HW'(ERR_HALF - 1) : HW'(KEY_HALF - 1);
    end else if (active_q) begin
      if (len_q == '0) active_q <= 1'b0;
      else len_q <= len_q - 1'b1;
      if (half_q == '0) begin
        phase_q <= ~phase_q;
        half_q  <= err_q ? HW'(ERR_HALF - 1) : HW'(KEY_HALF - 1);
      end else begin
        half_q <= half_q - 1'b1;
      end
    end
  end

  assign beep_o = active_q & phase_q;
endmodule

// File: rtl/key_state_reg.sv
module key_state_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [3:0] code_i,
  input  logic       rd_i,
  output logic [3:0] state_o
);
  // a fresh key wins over a read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= '0;
    else if (load_i) state_o <= code_i + 4'd1;
    else if (rd_i) state_o <= '0;
  end
endmodule

// File: rtl/pin_lock_ctrl.sv
module pin_lock_ctrl
  import pin_lock_pkg::*;
#(
  parameter int MAX_DIGITS    = 9,
  parameter int MIN_DIGITS    = 6,
  parameter int ATTEMPT_LIMIT = 15,
  parameter int TONE_LEN      = 7_000_000,
  parameter int KEY_HALF      = 25_000,
  parameter int ERR_HALF      = 60_000,
  parameter int RST_LEN       = 6,
  parameter logic [4*MAX_DIGITS-1:0] RST_PIN = 'h654321,
  localparam int CW = $clog2(MAX_DIGITS + 2),
  localparam int AW = $clog2(ATTEMPT_LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_valid_i,
  input  logic [3:0]    key_code_i,
  input  logic          host_rd_i,
  output logic [3:0]    key_state_o,
  output logic          unlock_o,
  output logic          beep_o,
  output logic          wipe_o,
  output logic [AW-1:0] attempts_o
);
  lock_state_e st_q, st_d;

  logic key_ok, is_digit, is_conf, is_f1;
  logic len_ok, match_stored, match_pend;
  logic fail, att_fail, ok_pin, buf_clr, load_pend, store_new;

  logic [4*MAX_DIGITS-1:0] entry_digits, stored_q, pend_q;
  logic [CW-1:0]           entry_cnt, stored_len_q, pend_len_q;
  logic [AW-1:0]           att_q;
  logic                    wipe_q;

  assign key_ok   = key_valid_i && key_code_i != KEY_NONE;
  assign is_digit = key_ok && key_code_i <= 4'd9;
  assign is_conf  = key_ok && key_code_i == KEY_OK;
  assign is_f1    = key_ok && key_code_i == KEY_F1;
  assign len_ok   = entry_cnt >= CW'(MIN_DIGITS) && entry_cnt <= CW'(MAX_DIGITS);

  pin_entry_buf #(.MAX_DIGITS(MAX_DIGITS), .CW(CW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (buf_clr),
    .digit_en_i (is_digit && st_q != ST_OPEN),
    .digit_i    (key_code_i),
    .digits_o   (entry_digits),
    .count_o    (entry_cnt)
  );

  pin_cmp #(.MAX_DIGITS(MAX_DIGITS), .CW(CW)) u_cmp_stored (
    .a_digits_i (entry_digits),
    .a_len_i    (entry_cnt),
    .b_digits_i (stored_q),
    .b_len_i    (stored_len_q),
    .eq_o       (match_stored)
  );

  pin_cmp #(.MAX_DIGITS(MAX_DIGITS), .CW(CW)) u_cmp_pend (
    .a_digits_i (entry_digits),
    .a_len_i    (entry_cnt),
    .b_digits_i (pend_q),
    .b_len_i    (pend_len_q),
    .eq_o       (match_pend)
  );

  always_comb begin
    st_d      = st_q;
    fail      = 1'b0;
    att_fail  = 1'b0;
    ok_pin    = 1'b0;
    buf_clr   = 1'b0;
    load_pend = 1'b0;
    store_new = 1'b0;
    if (is_f1 && st_q == ST_LOCKED) begin
      st_d    = ST_CHG_OLD;
      buf_clr = 1'b1;
    end else if (is_conf) begin
      buf_clr = 1'b1;
      unique case (st_q)
        ST_LOCKED, ST_CHG_OLD: begin
          if (len_ok && match_stored) begin
            ok_pin = 1'b1;
            st_d   = (st_q == ST_LOCKED) ? ST_OPEN : ST_CHG_NEW1;
          end else begin
            fail     = 1'b1;
            att_fail = 1'b1;
            st_d     = ST_LOCKED;
          end
        end
        ST_CHG_NEW1: begin
          if (len_ok) begin
            load_pend = 1'b1;
            st_d      = ST_CHG_NEW2;
          end else begin
            fail = 1'b1;
            st_d = ST_LOCKED;
          end
        end
        ST_CHG_NEW2: begin
          if (len_ok && match_pend) store_new = 1'b1;
          else fail = 1'b1;
          st_d = ST_LOCKED;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_LOCKED;
      att_q        <= '0;
      wipe_q       <= 1'b0;
      stored_q     <= RST_PIN;
      stored_len_q <= CW'(RST_LEN);
      pend_q       <= '0;
      pend_len_q   <= '0;
    end else begin
      st_q   <= st_d;
      wipe_q <= att_fail && att_q == AW'(ATTEMPT_LIMIT - 1);
      if (ok_pin) att_q <= '0;
      else if (att_fail) att_q <= (att_q == AW'(ATTEMPT_LIMIT - 1)) ? '0 : att_q + 1'b1;
      if (load_pend) begin
        pend_q     <= entry_digits;
        pend_len_q <= entry_cnt;
      end
      if (store_new) begin
        stored_q     <= pend_q;
        stored_len_q <= pend_len_q;
      end
    end
  end

  tone_gen #(.TONE_LEN(TONE_LEN), .KEY_HALF(KEY_HALF), .ERR_HALF(ERR_HALF)) u_tone (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (key_ok),
    .err_i   (fail),
    .beep_o  (beep_o)
  );

  key_state_reg u_ks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (key_ok),
    .code_i  (key_code_i),
    .rd_i    (host_rd_i),
    .state_o (key_state_o)
  );

  assign unlock_o   = st_q == ST_OPEN;
  assign wipe_o     = wipe_q;
  assign attempts_o = att_q;
endmodule

// File: rtl/pin_lock_sva.sv
module pin_lock_sva #(
  parameter int ATTEMPT_LIMIT = 15,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          key_valid_i,
  input logic [3:0]    key_code_i,
  input logic          host_rd_i,
  input logic [3:0]    key_state_o,
  input logic          unlock_o,
  input logic          beep_o,
  input logic          wipe_o,
  input logic [AW-1:0] attempts_o
);
  logic acc;
  assign acc = key_valid_i && key_code_i != 4'd15;

  p_key_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> key_state_o == $past(key_code_i) + 4'd1);
  p_read_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !acc) |=> key_state_o == 4'd0);
  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && !host_rd_i) |=> $stable(key_state_o));
  p_unlock_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |=> unlock_o);
  p_open_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_o) |-> attempts_o == '0);
  p_attempt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempts_o < AW'(ATTEMPT_LIMIT));
  p_wipe_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o |=> !wipe_o);
  p_wipe_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o |-> attempts_o == '0);
  p_beep_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> beep_o);
endmodule

bind pin_lock_ctrl pin_lock_sva #(.ATTEMPT_LIMIT(ATTEMPT_LIMIT), .AW(AW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_valid_i (key_valid_i),
  .key_code_i  (key_code_i),
  .host_rd_i   (host_rd_i),
  .key_state_o (key_state_o),
  .unlock_o    (unlock_o),
  .beep_o      (beep_o),
  .wipe_o      (wipe_o),
  .attempts_o  (attempts_o)
);

// File: tb/tb_pin_lock_ctrl.sv
module tb_pin_lock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TONE_LEN = 40;
  localparam int KEY_HALF = 2;
  localparam int ERR_HALF = 5;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic key_valid_i = 1'b0;
  logic [3:0] key_code_i = '0;
  logic host_rd_i = 1'b0;
  logic [3:0] key_state_o;
  logic unlock_o, beep_o, wipe_o;
  logic [AW-1:0] attempts_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_lock_ctrl #(.TONE_LEN(TONE_LEN), .KEY_HALF(KEY_HALF), .ERR_HALF(ERR_HALF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .key_valid_i(key_valid_i), .key_code_i(key_code_i),
    .host_rd_i(host_rd_i), .key_state_o(key_state_o), .unlock_o(unlock_o),
    .beep_o(beep_o), .wipe_o(wipe_o), .attempts_o(attempts_o));

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference model: 0 locked, 1 open, 2 old, 3 new1, 4 new2
  int mst, mcnt, slen, plen, matt, exp_ks;
  int mbuf[9], spin[9], ppin[9];
  bit exp_wipe, exp_err;

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit eq_arr(int len, int ref_len, int r[9], int b[9]);
    if (len != ref_len) return 0;
    for (int i = 0; i < len; i++) if (r[i] != b[i]) return 0;
    return 1;
  endfunction

  function automatic bit tone_at(int k, int half);
    return k < TONE_LEN && ((k / half) % 2 == 0);
  endfunction

  task automatic fail_att();
    exp_err = 1;
    if (matt == 14) begin matt = 0; exp_wipe = 1; end
    else matt++;
  endtask

  task automatic model_key(int code);
    bit lenok;
    exp_wipe = 0; exp_err = 0;
    if (code == 15) return;
    lenok = mcnt >= 6 && mcnt <= 9;
    if (code <= 9) begin
      if (mst != 1) begin
        if (mcnt < 9) mbuf[mcnt] = code;
        if (mcnt < 10) mcnt++;
      end
    end else if (code == 11) begin
      if (mst == 0) begin mst = 2; mcnt = 0; end
    end else if (code == 10) begin
      case (mst)
        0: if (lenok && eq_arr(mcnt, slen, spin, mbuf)) begin mst = 1; matt = 0; end
           else fail_att();
        2: if (lenok && eq_arr(mcnt, slen, spin, mbuf)) begin mst = 3; matt = 0; end
           else begin fail_att(); mst = 0; end
        3: if (lenok) begin ppin = mbuf; plen = mcnt; mst = 4; end
           else begin exp_err = 1; mst = 0; end
        4: begin
             if (lenok && eq_arr(mcnt, plen, ppin, mbuf)) begin spin = ppin; slen = plen; end
             else exp_err = 1;
             mst = 0;
           end
        default: ;
      endcase
      if (mst != 1) mcnt = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; key_valid_i = 0; host_rd_i = 0;
    mst = 0; mcnt = 0; slen = 6; matt = 0; exp_ks = 0;
    for (int i = 0; i < 9; i++) spin[i] = (i < 6) ? i + 1 : 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(key_state_o == 0 && !unlock_o && attempts_o == 0 && !wipe_o && !beep_o,
        "R13 reset state", {key_state_o, unlock_o, attempts_o, wipe_o, beep_o}, 0);
  endtask

  // drive one key, check k=0..2 after the capturing edge
  task automatic press(int code, bit rd = 0);
    @(negedge clk);
    key_valid_i = 1; key_code_i = 4'(code); host_rd_i = rd;
    model_key(code);
    if (code != 15) exp_ks = code + 1;
    else if (rd) exp_ks = 0;
    @(negedge clk);
    key_valid_i = 0; host_rd_i = 0;
    chk(key_state_o == 4'(exp_ks), "R2 key state", key_state_o, exp_ks);
    chk(unlock_o == (mst == 1), "R4 unlock", unlock_o, mst == 1);
    chk(attempts_o == 4'(matt), "R5 attempts", attempts_o, matt);
    chk(wipe_o == exp_wipe, "R6 wipe pulse", wipe_o, exp_wipe);
    if (code != 15) chk(beep_o == 1, "R10 beep start", beep_o, 1);
    @(negedge clk);
    chk(wipe_o == 0, "R6 wipe one cycle", wipe_o, 0);
    @(negedge clk);
    if (code != 15)
      chk(beep_o == exp_err, "R11 tone select", beep_o, exp_err);
  endtask

  task automatic enter(int n, int d[12]);
    for (int i = 0; i < n; i++) press(d[i]);
    press(10);
  endtask

  task automatic host_read();
    @(negedge clk);
    chk(key_state_o == 4'(exp_ks), "R2 poll value", key_state_o, exp_ks);
    host_rd_i = 1;
    @(negedge clk);
    host_rd_i = 0; exp_ks = 0;
    chk(key_state_o == 0, "R2 cleared after read", key_state_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int pin_ok[12] = '{1,2,3,4,5,6,0,0,0,0,0,0};
    int pin_new[12] = '{7,7,7,8,8,8,0,0,0,0,0,0};
    int pin_bad[12] = '{1,2,3,4,5,7,0,0,0,0,0,0};
    int pin_x[12] = '{2,2,2,2,2,2,0,0,0,0,0,0};
    void'($urandom(32'd2024));
    do_reset();

    // R3 short entry
    enter(5, pin_ok);
    chk(attempts_o == 1, "R3 five digits fail", attempts_o, 1);
    // R12 overflow: ten digits
    begin
      int ov[12] = '{1,2,3,4,5,6,1,2,3,4,0,0};
      enter(10, ov);
      chk(attempts_o == 2, "R12 overflow fails", attempts_o, 2);
    end
    // R11 full error trace after a failing confirm
    enter(6, pin_bad);
    for (int k = 3; k < TONE_LEN + 2; k++) begin
      @(negedge clk);
      chk(beep_o == tone_at(k, ERR_HALF), "R11 error trace", beep_o, tone_at(k, ERR_HALF));
    end
    // R1 code 15 ignored
    host_read();
    press(15);
    chk(key_state_o == 0 && !beep_o, "R1 code 15 ignored", {key_state_o, beep_o}, 0);
    // R10 key beep trace
    press(12);
    for (int k = 3; k < TONE_LEN + 2; k++) begin
      @(negedge clk);
      chk(beep_o == tone_at(k, KEY_HALF), "R10 key trace", beep_o, tone_at(k, KEY_HALF));
    end
    // R9 function keys between digits, R4 unlock
    press(1); press(2); press(3); press(12); press(4); press(5); press(13); press(6); press(14);
    press(10);
    chk(unlock_o == 1 && attempts_o == 0, "R9 R4 unlock clears", unlock_o, 1);
    // R7 F1 and digits ignored when open
    press(11); press(9); press(10);
    chk(unlock_o == 1, "R7 ignored while open", unlock_o, 1);
    // R2 key and read together
    press(7, 1);
    chk(key_state_o == 8, "R2 key wins over read", key_state_o, 8);

    // R6 wipe at limit
    do_reset();
    for (int i = 0; i < 15; i++) enter(6, pin_x);
    chk(attempts_o == 0, "R6 counter back to 0", attempts_o, 0);

    // R8 PIN change success
    do_reset();
    press(11); enter(6, pin_ok); enter(6, pin_new); enter(6, pin_new);
    enter(6, pin_ok);
    chk(!unlock_o && attempts_o == 1, "R8 old PIN retired", attempts_o, 1);
    enter(6, pin_new);
    chk(unlock_o == 1, "R8 new PIN unlocks", unlock_o, 1);
    // R8 mismatch keeps old PIN; wrong old PIN counts
    do_reset();
    press(11); enter(6, pin_bad);
    chk(attempts_o == 1, "R8 wrong old PIN counts", attempts_o, 1);
    press(11); enter(6, pin_ok); enter(6, pin_new); enter(6, pin_x);
    enter(6, pin_ok);
    chk(unlock_o == 1, "R8 mismatch keeps PIN", unlock_o, 1);

    // random entries
    do_reset();
    for (int t = 0; t < 40; t++) begin
      int n;
      if (mst == 1) do_reset();
      if ($urandom_range(0, 3) == 0) begin
        for (int i = 0; i < slen; i++) press(spin[i], bit'($urandom_range(0, 1)));
      end else begin
        n = $urandom_range(3, 11);
        for (int i = 0; i < n; i++) begin
          if ($urandom_range(0, 4) == 0) press($urandom_range(12, 14));
          press($urandom_range(0, 9), bit'($urandom_range(0, 1)));
        end
      end
      if ($urandom_range(0, 7) == 0 && mst == 0) press(11);
      press(10, bit'($urandom_range(0, 1)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule